// File: doc/BRIEF.md
# Phase-Frequency Detector With Lock Filter

This block compares the rising edges of two divided clocks: a reference clock (`ref_in`) and a feedback clock (`fb_in`). Both are sampled in one fast system clock domain. It drives two active-low correction pulses. `up_n` is low while the reference edge is ahead. `dn_n` is low while the feedback edge is ahead. The width of each pulse grows with the phase error, measured in system clock cycles. Once both edges of a comparison have arrived, the two internal flags are set together for exactly one sample and then cleared. That one-sample overlap keeps small errors from disappearing into a dead zone.

The block also provides two lock signals. `lock_raw` is the NAND of the two pulse outputs, so it is high whenever any correction pulse is active. `lock_o` is a filtered flag. It rises after a programmed number of consecutive comparisons whose only activity was the single-sample overlap. It falls as soon as `lock_raw` stays high for two samples in a row.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is asserted and right after it is released, `up_n` and `dn_n` are high, `lock_raw` is low and `lock_o` is low.
- R2: Falling edges and steady high levels on `ref_in` or `fb_in` produce no pulse on either output.
- R3: When `ref_in` rises d cycles before `fb_in` (d ≥ 1), `up_n` is low for d+1 cycles, `dn_n` is low for 1 cycle, and both return high on the same clock edge.
- R4: When `fb_in` rises d cycles before `ref_in` (d ≥ 1), `dn_n` is low for d+1 cycles, `up_n` is low for 1 cycle, and both return high on the same clock edge.
- R5: When both inputs rise in the same cycle, `up_n` and `dn_n` are both low for exactly one cycle. In general, any sample with both pulses low is followed by a sample with both high.
- R6: Extra rising edges of the leading input that arrive before the lagging input's edge neither restart nor extend the pulse. The width counts from the first edge.
- R7: With the default of 2 synchronizer stages, an output falls on the third rising clock edge after its input rises (SYNC_STAGES+1 edges in general).
- R8: `lock_raw` is high exactly when at least one of `up_n` and `dn_n` is low.
- R9: `lock_o` rises after `lock_thresh` consecutive clean comparisons. A clean comparison is one where both flags are set in a sample whose preceding sample had `lock_raw` low. Threshold values 0 and 1 both lock on the first clean comparison.
- R10: When `lock_raw` is high on two consecutive samples, `lock_o` falls and the clean-comparison count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Divided reference clock |
| fb_in | input | 1 | Divided feedback clock |
| lock_thresh | input | CNT_W | Number of consecutive clean comparisons required for lock |
| up_n | output | 1 | Active-low pulse, reference ahead |
| dn_n | output | 1 | Active-low pulse, feedback ahead |
| lock_raw | output | 1 | NAND of `up_n` and `dn_n` |
| lock_o | output | 1 | Filtered lock flag, high when locked |

## Verification
A flag that is stuck set, or that fails to clear after the overlap sample, shows up as a pulse wider than the edge spacing predicts. The scoreboard flags it when that pulse ends, a few cycles after the lagging edge. A lost or spurious edge in the synchronizer appears as a missing or unexpected pulse within SYNC_STAGES+1 cycles of the input change. A faulty lock counter shows as `lock_o` rising one comparison too early or too late, or failing to fall after a wide pulse. That is visible at the end of the affected comparison window.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

  // Saturating increment used by the lock counter.
  function automatic logic [31:0] sat_inc(input logic [31:0] value,
                                          input logic [31:0] limit);
    return (value >= limit) ? limit : value + 32'd1;
  endfunction

  // Lock is reached once the clean-comparison count meets the threshold.
  function automatic logic lock_reached(input logic [31:0] count,
                                        input logic [31:0] thresh);
    return count >= thresh;
  endfunction

  // Flag update: a set pair clears; otherwise each flag latches its edge.
  function automatic pfd_flags_t flags_next(input pfd_flags_t cur,
                                            input logic ref_rise,
                                            input logic fb_rise);
    pfd_flags_t nx;
    if (cur.up && cur.dn) begin
      nx = '0;
    end else begin
      nx.up = cur.up | ref_rise;
      nx.dn = cur.dn | fb_rise;
    end
    return nx;
  endfunction

endpackage

// File: rtl/pfd_lock_edge.sv
module pfd_lock_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R2: one input transition yields a single-sample event
  p_rise_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pfd_lock_core.sv
module pfd_lock_core
  import pfd_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_q,
  output logic dn_q,
  output logic both_set
);
  pfd_flags_t st, st_nx;

  always_comb st_nx = flags_next(st, ref_rise, fb_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_nx;
  end

  assign up_q     = st.up;
  assign dn_q     = st.dn;
  assign both_set = st.up & st.dn;

  p_up_follows_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !both_set) |=> up_q);
  p_dn_follows_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !both_set) |=> dn_q);
  p_overlap_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    both_set |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
  import pfd_lock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_raw,
  input  logic             both_set,
  input  logic [CNT_W-1:0] thresh,
  output logic             lock_o
);
  localparam logic [31:0] CNT_LIMIT = 32'((64'd1 << CNT_W) - 64'd1);

  logic             raw_prev;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             wide, clean_evt;

  assign wide      = lock_raw & raw_prev;
  assign clean_evt = both_set & ~raw_prev;
  assign cnt_nx    = CNT_W'(sat_inc(32'(cnt), CNT_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_prev <= 1'b0;
      cnt      <= '0;
      lock_o   <= 1'b0;
    end else begin
      raw_prev <= lock_raw;
      if (wide) begin
        cnt    <= '0;
        lock_o <= 1'b0;
      end else if (clean_evt) begin
        cnt <= cnt_nx;
        if (lock_reached(32'(cnt_nx), 32'(thresh))) lock_o <= 1'b1;
      end
    end
  end

  p_drop_on_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lock_o);
  p_lock_needs_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(both_set));
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_thresh,
  output logic             up_n,
  output logic             dn_n,
  output logic             lock_raw,
  output logic             lock_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] in_vec, rise_vec;
  logic           up_q, dn_q, both_set;

  assign in_vec = {fb_in, ref_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
    pfd_lock_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (in_vec[ch]),
      .rise (rise_vec[ch])
    );
  end

  pfd_lock_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(rise_vec[0]),
    .fb_rise (rise_vec[1]),
    .up_q    (up_q),
    .dn_q    (dn_q),
    .both_set(both_set)
  );

  assign up_n     = ~up_q;
  assign dn_n     = ~dn_q;
  assign lock_raw = ~(up_n & dn_n);

  pfd_lock_filter #(.CNT_W(CNT_W)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_raw(lock_raw),
    .both_set(both_set),
    .thresh  (lock_thresh),
    .lock_o  (lock_o)
  );

  // R5: a sample with both pulses low is followed by both idle
  p_pair_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && !dn_n) |=> (up_n && dn_n));
endmodule

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
  localparam int CW = 8;

  logic          clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, fb_in = 1'b0;
  logic [CW-1:0] thr = CW'(3);
  logic          up_n, dn_n, lock_raw, lock_o;

  pfd_lock_top #(.SYNC_STAGES(2), .CNT_W(CW)) i_pfd_lock_top (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .lock_thresh(thr), .up_n(up_n), .dn_n(dn_n),
    .lock_raw(lock_raw), .lock_o(lock_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int up_run = 0, dn_run = 0;
  bit done = 0;

  typedef struct { bit is_dn; int width; string req; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_done(bit is_dn, int w);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R2", is_dn ? "unexpected dn_n pulse" : "unexpected up_n pulse", w, 0);
    end else begin
      e = q.pop_front();
      chk(e.is_dn == is_dn && e.width == w, e.req,
          is_dn ? "dn_n pulse width" : "up_n pulse width", w, e.width);
    end
  endtask

  // Monitor: measures low pulses, pops the scoreboard, checks R8 each sample.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(lock_raw == (!up_n || !dn_n), "R8", "lock_raw", int'(lock_raw),
          int'(!up_n || !dn_n));
      if (!up_n) up_run++;
      else if (up_run > 0) begin pulse_done(0, up_run); up_run = 0; end
      if (!dn_n) dn_run++;
      else if (dn_run > 0) begin pulse_done(1, dn_run); dn_run = 0; end
    end
  end

  // Driver: bit k of each word is the input level for cycle k.
  task automatic play(logic [31:0] rw, logic [31:0] fw, int wu, int wd, string req);
    exp_t e;
    if (wu > 0) begin
      e.is_dn = 0; e.width = wu; e.req = req; q.push_back(e);
      e.is_dn = 1; e.width = wd; q.push_back(e);
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      ref_in = rw[k];
      fb_in  = fw[k];
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    chk(up_n && dn_n, "R1", "pulses idle in reset", int'(up_n & dn_n), 1);
    chk(!lock_raw && !lock_o, "R1", "lock low in reset", int'(lock_raw | lock_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(up_n && dn_n && !lock_raw && !lock_o, "R1", "state after release",
        int'({up_n, dn_n, lock_raw, lock_o}), 4'b1100);

    // Lock build-up, threshold 3
    play(32'h70, 32'h70, 1, 1, "R5");
    play(32'h70, 32'h70, 1, 1, "R5");
    chk(!lock_o, "R9", "lock after 2 clean", int'(lock_o), 0);
    play(32'h70, 32'h70, 1, 1, "R5");
    chk(lock_o, "R9", "lock after 3 clean", int'(lock_o), 1);
    // Wide pulse drops lock, count restarts
    play(32'h70, 32'h1C0, 3, 1, "R3");
    chk(!lock_o, "R10", "lock after wide pulse", int'(lock_o), 0);
    play(32'h70, 32'h70, 1, 1, "R5");
    play(32'h70, 32'h70, 1, 1, "R5");
    chk(!lock_o, "R10", "count restarted (2 clean)", int'(lock_o), 0);
    play(32'h70, 32'h70, 1, 1, "R5");
    chk(lock_o, "R10", "relock after 3 clean", int'(lock_o), 1);
    // Threshold zero behaves as one
    thr = '0;
    play(32'hE0, 32'h70, 1, 2, "R4");
    chk(!lock_o, "R10", "lock after 2-wide dn pulse", int'(lock_o), 0);
    play(32'h70, 32'h70, 1, 1, "R5");
    chk(lock_o, "R9", "threshold 0 locks on first clean", int'(lock_o), 1);
    thr = CW'(3);

    // Latency: ref rises, fb follows 4 cycles later
    e.is_dn = 0; e.width = 5; e.req = "R7"; q.push_back(e);
    e.is_dn = 1; e.width = 1; q.push_back(e);
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    @(negedge clk); chk(up_n, "R7", "up_n before third edge", int'(up_n), 1);
    @(negedge clk); chk(!up_n, "R7", "up_n at third edge", int'(up_n), 0);
    @(negedge clk); fb_in = 1'b1;
    @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
    repeat (12) @(negedge clk);

    // Pulse-width patterns
    play(32'h70, 32'hE00, 6, 1, "R3");
    play(32'h380, 32'h70, 1, 4, "R4");
    play(32'h7000, 32'h330, 1, 9, "R6");
    play(32'h330, 32'h7000, 9, 1, "R6");
    // Long high levels then falling edges: only the aligned pair
    play(32'h7FFF_FFF0, 32'h7FFF_FFF0, 1, 1, "R2");
    chk(up_n && dn_n, "R2", "no pulse from falling edges", int'(up_n & dn_n), 1);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule